// File: doc/BRIEF.md
# Multichannel SAR Converter Serial Host

This block is the host end of a four-wire serial link to a 16-channel, 12-bit successive-approximation converter. One start strobe runs one 16-bit frame. The block pulls chip select low, which also starts the conversion, and then runs a serial clock made from the system clock by a fixed divider. While the clock runs, it shifts a 16-bit control word out on the data line and takes a 16-bit result frame in. The block passes the control word on unchanged, so the converter's channel address, range, coding and sequencing fields stay under the caller's control.

The returned frame carries a 4-bit channel tag first and a 12-bit sample after it. The block splits the frame into these two fields. On request it also recodes the sample between offset-binary and two's-complement form by inverting the sample MSB. The recode choice is latched with each start strobe, so it can differ from frame to frame. When the frame ends, chip select rises and stays high through a guard gap. After the gap the block pulses a result valid signal for one cycle. Busy stays high from the accepted start until that pulse.

Top module: `adc_serial_host`

## Requirements
- R1: While rst is high: adc_cs_n=1, adc_sclk=1, adc_din=0, busy=0, res_valid=0, res_tag=0, res_sample=0.
- R2: A start sampled while busy is low is accepted. One cycle later busy=1, adc_cs_n=0, and adc_din carries bit 15 of ctrl_word.
- R3: While adc_cs_n is low there are exactly 16 falling and 16 rising adc_sclk edges. The first falling edge comes DIV_HALF cycles after chip select falls, and every later edge comes DIV_HALF cycles after the one before. adc_sclk is high whenever adc_cs_n is high.
- R4: The control word goes out MSB first, one bit per rising edge, so the converter reads bit 15-k on falling edge k+1. adc_din never changes in a cycle in which adc_sclk falls.
- R5: adc_dout is sampled on each rising edge, so frame bit 15-k is taken on rising edge k+1. Frame bits 15..12 become res_tag, and bits 11..0 become res_sample.
- R6: If recode was 0 at the accepted start, res_sample equals frame bits 11..0. If it was 1, res_sample is the same value with bit 11 inverted. Changes to recode after the start have no effect on that frame.
- R7: adc_cs_n rises DIV_HALF cycles after the 16th rising edge and stays high for at least 2*DIV_HALF cycles before the next frame can begin. adc_cs_n is high whenever busy is low.
- R8: res_valid is high for exactly one cycle, 35*DIV_HALF cycles after the edge that accepted start. busy falls on the same edge. res_tag and res_sample change only when res_valid rises.
- R9: A start sampled while busy is high is ignored. The frame in progress and its control word are unchanged, and no new frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to run a frame |
| ctrl_word | input | 16 | Control word shifted to the converter, MSB first |
| recode | input | 1 | 1 = invert the sample MSB (offset-binary to/from two's complement) |
| adc_dout | input | 1 | Serial result from the converter |
| adc_cs_n | output | 1 | Active-low chip select, which also starts conversion |
| adc_sclk | output | 1 | Serial clock, idles high |
| adc_din | output | 1 | Serial control data to the converter |
| busy | output | 1 | Frame in progress, from accepted start to result valid |
| res_valid | output | 1 | One-cycle result strobe |
| res_tag | output | 4 | Channel tag from the returned frame |
| res_sample | output | 12 | Sample, recoded if requested |

## Verification
Chip select, busy and the first data bit are due one cycle after the edge that accepts start. The result strobe is due exactly 35*DIV_HALF cycles after that edge, and chip select rises 2*DIV_HALF cycles before the strobe. The bench drives start on a falling clock edge and then counts falling edges until res_valid appears. It compares that count with the expected figure, so a frame that ends early or late fails the check. A converter model in the bench logs the cycle of every serial clock edge and the cycle of the chip select rise. From these the bench checks the spacing of each edge and the guard gap in whole cycles.

// File: rtl/ash_pkg.sv
package ash_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TAIL  = 2'd2,
    ST_GAP   = 2'd3
  } ash_state_e;

  // Frame length in serial clock half periods from chip select fall to the
  // result strobe: two per bit, one tail, two of guard gap.
  function automatic int frame_halves(input int frame_bits);
    return 2 * frame_bits + 3;
  endfunction

endpackage

// File: rtl/ash_half_timer.sv
module ash_half_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             tick
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign tick = (cnt == '0);

endmodule

// File: rtl/ash_frame_shifter.sv
module ash_frame_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift,
  input  logic         ser_in,
  output logic         ser_out,
  output logic [W-1:0] rx_word
);

  logic [W-1:0] tx_q;
  logic [W-1:0] rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load) begin
      tx_q <= load_word;
      rx_q <= '0;
    end else if (shift) begin
      tx_q <= {tx_q[W-2:0], 1'b0};
      rx_q <= {rx_q[W-2:0], ser_in};
    end
  end

  assign ser_out = tx_q[W-1];
  assign rx_word = rx_q;

endmodule

// File: rtl/ash_result_fmt.sv
module ash_result_fmt #(
  parameter int TAG_W     = 4,
  parameter int SAMPLE_W  = 12,
  parameter bit RECODE_EN = 1'b1,
  localparam int FRAME_W  = TAG_W + SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                capture,
  input  logic                recode,
  input  logic [FRAME_W-1:0]  frame,
  output logic                valid,
  output logic [TAG_W-1:0]    tag,
  output logic [SAMPLE_W-1:0] sample
);

  logic [SAMPLE_W-1:0] raw;
  logic [SAMPLE_W-1:0] coded;

  assign raw = frame[SAMPLE_W-1:0];

  generate
    if (RECODE_EN) begin : g_recode
      assign coded = {raw[SAMPLE_W-1] ^ recode, raw[SAMPLE_W-2:0]};
    end else begin : g_plain
      logic unused_recode;
      assign unused_recode = recode;
      assign coded = raw;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= 1'b0;
      tag    <= '0;
      sample <= '0;
    end else begin
      valid <= capture;
      if (capture) begin
        tag    <= frame[FRAME_W-1 -: TAG_W];
        sample <= coded;
      end
    end
  end

endmodule

// File: rtl/adc_serial_host.sv
module adc_serial_host
  import ash_pkg::*;
#(
  parameter int DIV_HALF  = 2,
  parameter int TAG_W     = 4,
  parameter int SAMPLE_W  = 12,
  parameter bit RECODE_EN = 1'b1,
  localparam int FRAME_W  = TAG_W + SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [FRAME_W-1:0]  ctrl_word,
  input  logic                recode,
  input  logic                adc_dout,
  output logic                adc_cs_n,
  output logic                adc_sclk,
  output logic                adc_din,
  output logic                busy,
  output logic                res_valid,
  output logic [TAG_W-1:0]    res_tag,
  output logic [SAMPLE_W-1:0] res_sample
);

  localparam int CNT_W  = $clog2(2 * DIV_HALF) + 1;
  localparam int BIT_CW = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0]  HALF_LD  = CNT_W'(DIV_HALF - 1);
  localparam logic [CNT_W-1:0]  GAP_LD   = CNT_W'(2 * DIV_HALF - 1);
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(FRAME_W - 1);

  ash_state_e        state;
  logic [BIT_CW-1:0] bit_cnt;
  logic              cs_q;
  logic              sclk_q;
  logic              busy_q;
  logic              recode_q;

  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tick;
  logic              sh_load;
  logic              sh_shift;
  logic              fmt_capture;
  logic [FRAME_W-1:0] rx_word;

  always_comb begin
    tmr_load    = 1'b0;
    tmr_val     = HALF_LD;
    sh_load     = 1'b0;
    sh_shift    = 1'b0;
    fmt_capture = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          tmr_load = 1'b1;
          sh_load  = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          tmr_load = 1'b1;
          sh_shift = ~sclk_q;
        end
      end
      ST_TAIL: begin
        if (tick) begin
          tmr_load = 1'b1;
          tmr_val  = GAP_LD;
        end
      end
      ST_GAP: begin
        fmt_capture = tick;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      cs_q     <= 1'b1;
      sclk_q   <= 1'b1;
      busy_q   <= 1'b0;
      recode_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            cs_q     <= 1'b0;
            busy_q   <= 1'b1;
            recode_q <= recode;
            bit_cnt  <= '0;
            state    <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            sclk_q <= ~sclk_q;
            if (!sclk_q) begin
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == LAST_BIT) begin
                state <= ST_TAIL;
              end
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            cs_q  <= 1'b1;
            state <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (tick) begin
            busy_q <= 1'b0;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  ash_half_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .tick     (tick)
  );

  ash_frame_shifter #(
    .W(FRAME_W)
  ) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (sh_load),
    .load_word (ctrl_word),
    .shift     (sh_shift),
    .ser_in    (adc_dout),
    .ser_out   (adc_din),
    .rx_word   (rx_word)
  );

  ash_result_fmt #(
    .TAG_W     (TAG_W),
    .SAMPLE_W  (SAMPLE_W),
    .RECODE_EN (RECODE_EN)
  ) u_fmt (
    .clk     (clk),
    .rst     (rst),
    .capture (fmt_capture),
    .recode  (recode_q),
    .frame   (rx_word),
    .valid   (res_valid),
    .tag     (res_tag),
    .sample  (res_sample)
  );

  assign adc_cs_n = cs_q;
  assign adc_sclk = sclk_q;
  assign busy     = busy_q;

endmodule

// File: rtl/ash_checker.sv
module ash_checker #(
  parameter int TAG_W    = 4,
  parameter int SAMPLE_W = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic                adc_cs_n,
  input logic                adc_sclk,
  input logic                adc_din,
  input logic                busy,
  input logic                res_valid,
  input logic [TAG_W-1:0]    res_tag,
  input logic [SAMPLE_W-1:0] res_sample
);

  AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !adc_cs_n)); // R2

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    adc_cs_n |-> adc_sclk); // R3

  AST_DIN_HELD_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_sclk) |-> $stable(adc_din)); // R4

  AST_CS_HIGH_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> adc_cs_n); // R7

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid); // R8

  AST_BUSY_ENDS_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> res_valid); // R8

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> ($stable(res_tag) && $stable(res_sample))); // R8

  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && busy && !adc_cs_n) |=> (busy && !res_valid)); // R9

endmodule

bind adc_serial_host ash_checker #(
  .TAG_W    (TAG_W),
  .SAMPLE_W (SAMPLE_W)
) u_ash_checker (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .adc_cs_n   (adc_cs_n),
  .adc_sclk   (adc_sclk),
  .adc_din    (adc_din),
  .busy       (busy),
  .res_valid  (res_valid),
  .res_tag    (res_tag),
  .res_sample (res_sample)
);

// File: tb/adc_serial_host_test.sv
module adc_serial_host_test;

  localparam int H   = 2;
  localparam int TW  = 4;
  localparam int SW  = 12;
  localparam int FW  = TW + SW;
  localparam int LAT = (2 * FW + 3) * H;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [FW-1:0] ctrl = '0;
  logic          recode = 1'b0;
  logic          adc_dout = 1'b0;
  logic          adc_cs_n, adc_sclk, adc_din, busy, res_valid;
  logic [TW-1:0] res_tag;
  logic [SW-1:0] res_sample;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_serial_host #(.DIV_HALF(H), .TAG_W(TW), .SAMPLE_W(SW)) uut (
    .clk(clk), .rst(rst), .start(start), .ctrl_word(ctrl), .recode(recode),
    .adc_dout(adc_dout), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
    .adc_din(adc_din), .busy(busy), .res_valid(res_valid),
    .res_tag(res_tag), .res_sample(res_sample)
  );

  // Converter model: records edges, captures din on falling edges and
  // presents frame bits on falling edges.
  logic [FW-1:0] dev_word = '0;
  logic [FW-1:0] dev_got = '0;
  int dev_falls = 0, dev_rises = 0, dev_gap_bad = 0, dev_last = 0, dev_cs_rise = 0;
  logic prev_s = 1'b1, prev_c = 1'b1;

  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (prev_c && !adc_cs_n) begin
          dev_falls = 0; dev_rises = 0; dev_got = '0; dev_gap_bad = 0; dev_last = cyc;
        end else if (!adc_cs_n && (prev_s != adc_sclk)) begin
          if (cyc - dev_last != H) dev_gap_bad++;
          dev_last = cyc;
          if (!adc_sclk) begin
            dev_got = {dev_got[FW-2:0], adc_din};
            if (dev_falls < FW) adc_dout = dev_word[FW-1-dev_falls];
            dev_falls++;
          end else begin
            dev_rises++;
          end
        end else if (!prev_c && adc_cs_n) begin
          if (cyc - dev_last != H) dev_gap_bad++;
          dev_cs_rise = cyc;
        end
      end
      prev_s = adc_sclk;
      prev_c = adc_cs_n;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] exp_sample(input logic [FW-1:0] w, input logic rc);
    return rc ? {~w[SW-1], w[SW-2:0]} : w[SW-1:0];
  endfunction

  task automatic run_frame(input logic [FW-1:0] cw, input logic rc,
                           input logic [FW-1:0] word, input bit inject);
    int n;
    int v_cyc;
    logic [TW-1:0] t_hold;
    logic [SW-1:0] s_hold;
    dev_word = word;
    @(negedge clk);
    ctrl = cw; recode = rc; start = 1'b1;
    @(negedge clk);
    start = 1'b0; ctrl = ~cw; recode = ~rc;
    check(busy == 1'b1, "R2", "busy after start", busy, 1);
    check(adc_cs_n == 1'b0, "R2", "cs_n after start", adc_cs_n, 0);
    check(adc_din == cw[FW-1], "R2", "first din bit", adc_din, cw[FW-1]);
    n = 0;
    while (!res_valid && n < LAT + 20) begin
      @(negedge clk);
      n++;
      if (inject && n == 9)  start = 1'b1;
      if (inject && n == 10) start = 1'b0;
    end
    v_cyc = cyc;
    check(n == LAT, "R8", "valid latency", n, LAT);
    check(busy == 1'b0, "R8", "busy at valid", busy, 0);
    check(res_tag == word[FW-1 -: TW], "R5", "tag", res_tag, word[FW-1 -: TW]);
    check(res_sample == exp_sample(word, rc), "R6", "sample", res_sample, exp_sample(word, rc));
    check(dev_got == cw, inject ? "R9" : "R4", "control word at converter", dev_got, cw);
    check(dev_falls == FW && dev_rises == FW, "R3", "edge counts", dev_falls * 100 + dev_rises, FW * 101);
    check(dev_gap_bad == 0, "R3", "edge spacing errors", dev_gap_bad, 0);
    check(v_cyc - dev_cs_rise == 2 * H, "R7", "cs high before valid", v_cyc - dev_cs_rise, 2 * H);
    t_hold = res_tag; s_hold = res_sample;
    @(negedge clk);
    check(res_valid == 1'b0, "R8", "valid width", res_valid, 0);
    if (inject) check(adc_cs_n == 1'b1 && busy == 1'b0, "R9", "no frame from ignored start",
                      {adc_cs_n, busy}, 2);
    check(res_tag == t_hold && res_sample == s_hold, "R8", "result held",
          {res_tag, res_sample}, {t_hold, s_hold});
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=%0d expected=finished", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0a11));
    repeat (4) @(negedge clk);
    check(adc_cs_n && adc_sclk && !adc_din && !busy && !res_valid, "R1", "control outputs in reset",
          {adc_cs_n, adc_sclk, adc_din, busy, res_valid}, 5'b11000);
    check(res_tag == '0 && res_sample == '0, "R1", "result outputs in reset",
          {res_tag, res_sample}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    run_frame(16'h0000, 1'b0, 16'h0000, 1'b0);
    run_frame(16'hFFFF, 1'b0, 16'hFFFF, 1'b0);
    run_frame(16'h8311, 1'b1, 16'h5800, 1'b0); // R6 mid-scale to zero
    run_frame(16'hA5C3, 1'b1, 16'hF7FF, 1'b0); // R6 below mid-scale
    run_frame(16'h1234, 1'b0, 16'h3ABC, 1'b1); // R9 start during frame
    for (int i = 0; i < 40; i++) begin
      run_frame(16'($urandom), 1'($urandom), 16'($urandom), (i % 7) == 3);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule